// File: doc/BRIEF.md
# Warp Divergence Mask Sequencer

This block governs which lanes of a single 32-lane warp are live while the warp runs through a two-way conditional branch. When a branch event arrives it carries the per-lane branch outcome, the mask of lanes live at the branch, and the instruction count of each side. The block splits the live lanes into a taken group and a fall-through group. It issues the taken side first, under the taken group's mask. It then issues the fall-through side under the complementary mask. Once both sides are done, the pre-branch mask comes back into force.

A side that no live lane follows is skipped. A uniform branch therefore costs only its own length, and a real split costs the sum of both lengths. The cost follows the number of distinct paths and not how many lanes sit on each one. Only one level of divergence exists. While a split is in flight a busy flag is raised, and any branch event offered during that time is dropped. Two running tallies, one of issue slots and one of lane-cycles lost to masking, let a surrounding test measure lane utilisation.

Top module: `div_mask_seq`

## Requirements
- R1: After reset, issue_valid and busy are 0, issue_mask is all ones, and both tallies read 0.
- R2: An event accepted at a clock edge with a non-empty taken group (br_taken AND br_entry_mask) and a non-zero br_len_taken is followed, from the next cycle on, by br_len_taken consecutive cycles with issue_valid 1 and issue_mask equal to that taken group.
- R3: The fall-through group is (NOT br_taken) AND br_entry_mask. If it is non-empty and br_len_fall is non-zero, br_len_fall issue cycles with that mask follow. They come right after the taken side, or right after acceptance when the taken side is skipped.
- R4: If every live lane takes the branch, only the taken side is issued, for br_len_taken cycles, whatever br_len_fall is.
- R5: If no live lane takes the branch, only the fall-through side is issued, for br_len_fall cycles, starting the cycle after acceptance.
- R6: In the cycle after the last issue cycle, issue_valid is 0, busy is 0, and issue_mask equals the br_entry_mask of the accepted event.
- R7: busy is 1 on every issue cycle of a split. A br_valid pulse while busy is 1 changes neither the issue stream nor the mask restored afterwards.
- R8: No lane outside br_entry_mask is ever issued. A side whose length is 0 issues nothing.
- R9: slot_count rises by one for each issue cycle, so it totals the summed lengths of the sides actually issued.
- R10: masked_lane_count rises, for each issue cycle, by 32 minus the number of ones in issue_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | Branch event strobe |
| br_taken | input | 32 | Per-lane branch outcome, 1 = taken |
| br_entry_mask | input | 32 | Lanes live when the branch is reached |
| br_len_taken | input | 8 | Instruction count of the taken side |
| br_len_fall | input | 8 | Instruction count of the fall-through side |
| busy | output | 1 | A split is in flight; events are dropped |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_mask | output | 32 | Live lanes for the issue; pre-branch mask when idle |
| slot_count | output | 32 | Running count of issue cycles |
| masked_lane_count | output | 32 | Running count of masked lane-cycles |

## Verification
The branch is driven with an even half split, a single taken lane against 31 fall-through lanes with unequal lengths, and outcomes where every live lane or no live lane takes the branch. These patterns separate a true two-path sequence from a uniform single path, and show whether cost follows path count or lane count. A partial entry mask with taken bits only on dead lanes, and a zero-length taken side, show that dead lanes and empty sides produce no issue. A second event offered mid-split must leave the expected mask stream and the restored mask untouched.

// File: rtl/div_pkg.sv
// Shared types for the warp divergence sequencer.
package div_pkg;
    // Which side of the branch is being issued.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TAKEN = 2'd1,
        PH_FALL  = 2'd2
    } phase_e;
endpackage

// File: rtl/div_split.sv
// Splits the live lanes by branch outcome and decides which sides run.
// Assumes: purely combinational; a side runs only if it has lanes and
// a non-zero length.
module div_split #(
    parameter int LANES = 32,
    parameter int LEN_W = 8
) (
    input  logic [LANES-1:0] taken,
    input  logic [LANES-1:0] entry_mask,
    input  logic [LEN_W-1:0] len_taken,
    input  logic [LEN_W-1:0] len_fall,
    output logic [LANES-1:0] grp_taken,
    output logic [LANES-1:0] grp_fall,
    output logic             run_taken,
    output logic             run_fall
);
    // Form the two lane groups and the run decisions.
    always_comb begin
        grp_taken = taken & entry_mask;
        grp_fall  = ~taken & entry_mask;
        run_taken = (grp_taken != '0) && (len_taken != '0);
        run_fall  = (grp_fall != '0) && (len_fall != '0);
    end
endmodule

// File: rtl/path_seq.sv
// Sequences the taken side, then the fall-through side, then restores the
// pre-branch mask. Assumes single-level divergence; events offered while a
// split is in flight are dropped.
module path_seq
    import div_pkg::*;
#(
    parameter int LANES = 32,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [LANES-1:0] ev_entry,
    input  logic [LANES-1:0] grp_taken,
    input  logic [LANES-1:0] grp_fall,
    input  logic             run_taken,
    input  logic             run_fall,
    input  logic [LEN_W-1:0] len_taken,
    input  logic [LEN_W-1:0] len_fall,
    output logic             busy,
    output logic             issue_valid,
    output logic [LANES-1:0] issue_mask
);
    phase_e           phase;
    logic [LEN_W-1:0] remain;
    logic [LEN_W-1:0] fall_len_q;
    logic             fall_run_q;
    logic [LANES-1:0] taken_q;
    logic [LANES-1:0] fall_q;
    logic [LANES-1:0] saved_q;
    logic             accept;

    assign accept = ev_valid && (phase == PH_IDLE);

    // Phase machine with a per-side countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            remain     <= '0;
            fall_len_q <= '0;
            fall_run_q <= 1'b0;
            taken_q    <= '0;
            fall_q     <= '0;
            saved_q    <= '1;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    saved_q    <= ev_entry;
                    taken_q    <= grp_taken;
                    fall_q     <= grp_fall;
                    fall_len_q <= len_fall;
                    fall_run_q <= run_fall;
                    if (run_taken) begin
                        phase  <= PH_TAKEN;
                        remain <= len_taken;
                    end else if (run_fall) begin
                        phase  <= PH_FALL;
                        remain <= len_fall;
                    end
                end
                PH_TAKEN: if (remain == LEN_W'(1)) begin
                    if (fall_run_q) begin
                        phase  <= PH_FALL;
                        remain <= fall_len_q;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end else begin
                    remain <= remain - LEN_W'(1);
                end
                PH_FALL: if (remain == LEN_W'(1)) begin
                    phase <= PH_IDLE;
                end else begin
                    remain <= remain - LEN_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Drive the issue strobe and the mask for the current phase.
    always_comb begin
        issue_valid = (phase != PH_IDLE);
        busy        = issue_valid;
        case (phase)
            PH_TAKEN: issue_mask = taken_q;
            PH_FALL:  issue_mask = fall_q;
            default:  issue_mask = saved_q;
        endcase
    end

    // R3: the two sides of one split never share a lane
    disjoint_sides_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FALL && $past(phase) == PH_TAKEN) |->
        ((issue_mask & $past(issue_mask)) == '0));

    // R8: an issued mask stays inside the pre-branch mask
    inside_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ((issue_mask & ~saved_q) == '0));

    // R8: an issue never goes out with no live lane
    live_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (issue_mask != '0));

    // R7: an event offered while busy leaves the restore mask unchanged
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ev_valid) |=> $stable(saved_q));
endmodule

// File: rtl/issue_tally.sv
// Running tallies of issue slots and masked lane-cycles.
// Assumes counters wrap at their width.
module issue_tally #(
    parameter int LANES = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [LANES-1:0] issue_mask,
    output logic [CNT_W-1:0] slot_count,
    output logic [CNT_W-1:0] masked_lane_count
);
    localparam int POP_W = $clog2(LANES + 1);

    logic [POP_W-1:0] live;
    logic [POP_W-1:0] idle;
    logic             armed;

    // Count live lanes in the issued mask.
    always_comb begin
        live = '0;
        for (int i = 0; i < LANES; i++) live = live + POP_W'(issue_mask[i]);
        idle = POP_W'(LANES) - live;
    end

    // Accumulate both tallies on issue cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_count        <= '0;
            masked_lane_count <= '0;
            armed             <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (issue_valid) begin
                slot_count        <= slot_count + CNT_W'(1);
                masked_lane_count <= masked_lane_count + CNT_W'(idle);
            end
        end
    end

    // R9: each issue cycle adds exactly one slot
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(issue_valid)) |-> (slot_count == $past(slot_count) + CNT_W'(1)));

    // R10: the masked tally never grows by more than the lane count
    lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((masked_lane_count - $past(masked_lane_count)) <= CNT_W'(LANES)));
endmodule

// File: rtl/div_mask_seq.sv
// Top: active-lane mask sequencer for one warp through a two-way branch.
// Assumes one divergence level; branch events during a split are dropped.
module div_mask_seq #(
    parameter int LANES = 32,
    parameter int LEN_W = 8,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken,
    input  logic [LANES-1:0] br_entry_mask,
    input  logic [LEN_W-1:0] br_len_taken,
    input  logic [LEN_W-1:0] br_len_fall,
    output logic             busy,
    output logic             issue_valid,
    output logic [LANES-1:0] issue_mask,
    output logic [CNT_W-1:0] slot_count,
    output logic [CNT_W-1:0] masked_lane_count
);
    logic [LANES-1:0] grp_taken;
    logic [LANES-1:0] grp_fall;
    logic             run_taken;
    logic             run_fall;

    div_split #(.LANES(LANES), .LEN_W(LEN_W)) u_split (
        .taken      (br_taken),
        .entry_mask (br_entry_mask),
        .len_taken  (br_len_taken),
        .len_fall   (br_len_fall),
        .grp_taken  (grp_taken),
        .grp_fall   (grp_fall),
        .run_taken  (run_taken),
        .run_fall   (run_fall)
    );

    path_seq #(.LANES(LANES), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid    (br_valid),
        .ev_entry    (br_entry_mask),
        .grp_taken   (grp_taken),
        .grp_fall    (grp_fall),
        .run_taken   (run_taken),
        .run_fall    (run_fall),
        .len_taken   (br_len_taken),
        .len_fall    (br_len_fall),
        .busy        (busy),
        .issue_valid (issue_valid),
        .issue_mask  (issue_mask)
    );

    issue_tally #(.LANES(LANES), .CNT_W(CNT_W)) u_tally (
        .clk               (clk),
        .rst_n             (rst_n),
        .issue_valid       (issue_valid),
        .issue_mask        (issue_mask),
        .slot_count        (slot_count),
        .masked_lane_count (masked_lane_count)
    );
endmodule

// File: tb/div_mask_seq_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected issue masks, the monitor
// pops and compares them on every issue cycle.
module div_mask_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] br_taken = '0;
    logic [31:0] br_entry_mask = '0;
    logic [7:0]  br_len_taken = '0;
    logic [7:0]  br_len_fall = '0;
    logic        busy;
    logic        issue_valid;
    logic [31:0] issue_mask;
    logic [31:0] slot_count;
    logic [31:0] masked_lane_count;

    int          tests = 0;
    int          fails = 0;
    logic [31:0] exp_q[$];
    logic [31:0] exp_slots = '0;
    logic [31:0] exp_lanes = '0;

    always #4 clk = ~clk;

    div_mask_seq uut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
        .br_entry_mask(br_entry_mask), .br_len_taken(br_len_taken),
        .br_len_fall(br_len_fall), .busy(busy), .issue_valid(issue_valid),
        .issue_mask(issue_mask), .slot_count(slot_count),
        .masked_lane_count(masked_lane_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: every issue cycle must match the head of the queue (R2/R3/R8).
    always @(negedge clk) begin
        if (rst_n && issue_valid) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R8 actual=%h expected=no issue", issue_mask);
            end else begin
                check("R2/R3 issue mask", issue_mask, exp_q.pop_front());
            end
        end
    end

    // Driver: queue expectations, pulse one branch event, check the end state.
    task automatic branch(input logic [31:0] tk, input logic [31:0] en,
                          input int lt, input int ln, input bit inject);
        logic [31:0] t = tk & en;
        logic [31:0] n = ~tk & en;
        int k = 0;
        if (t != 0) for (int i = 0; i < lt; i++) begin
            exp_q.push_back(t); k++; exp_lanes += 32 - $countones(t);
        end
        if (n != 0) for (int i = 0; i < ln; i++) begin
            exp_q.push_back(n); k++; exp_lanes += 32 - $countones(n);
        end
        exp_slots += k;
        br_taken = tk; br_entry_mask = en;
        br_len_taken = 8'(lt); br_len_fall = 8'(ln);
        br_valid = 1'b1;
        @(negedge clk);
        br_valid = 1'b0;
        if (inject) begin
            @(negedge clk); @(negedge clk);
            check("R7 busy mid-split", {31'd0, busy}, 32'd1);
            br_taken = '1; br_entry_mask = 32'h1;
            br_len_taken = 8'd9; br_len_fall = 8'd9;
            br_valid = 1'b1;
            @(negedge clk);
            br_valid = 1'b0;
            repeat (k - 3) @(negedge clk);
        end else begin
            repeat (k) @(negedge clk);
        end
        check("R6 issue_valid low after", {31'd0, issue_valid}, 32'd0);
        check("R6 busy low after", {31'd0, busy}, 32'd0);
        check("R6 mask restored", issue_mask, en);
        check("R2/R3 all expected issued", exp_q.size(), 32'd0);
        check("R9 slot_count", slot_count, exp_slots);
        check("R10 masked_lane_count", masked_lane_count, exp_lanes);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("  [TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        join_none
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 issue_valid", {31'd0, issue_valid}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 mask", issue_mask, 32'hFFFF_FFFF);
        check("R1 slot_count", slot_count, 32'd0);
        check("R1 masked_lane_count", masked_lane_count, 32'd0);
        // R2 R3: even split with equal lengths costs both sides
        branch(32'h0000_FFFF, 32'hFFFF_FFFF, 3, 3, 1'b0);
        // R2 R3: one lane taken, unequal lengths
        branch(32'h0000_0001, 32'hFFFF_FFFF, 2, 5, 1'b0);
        // R4: uniform taken
        branch(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4, 7, 1'b0);
        // R5: uniform not taken
        branch(32'h0000_0000, 32'hFFFF_FFFF, 4, 2, 1'b0);
        // R2 R3: partial entry mask, mixed outcome
        branch(32'h0F0F_0F0F, 32'h00FF_00FF, 2, 2, 1'b0);
        // R8: taken bits only on dead lanes
        branch(32'hFF00_0000, 32'h00FF_00FF, 3, 2, 1'b0);
        // R8: zero-length taken side issues nothing
        branch(32'h0000_00F0, 32'hFFFF_FFFF, 0, 3, 1'b0);
        // R8: no live lanes at all
        branch(32'h0000_00F0, 32'h0000_0000, 3, 3, 1'b0);
        // R7: event offered mid-split is dropped
        branch(32'hAAAA_AAAA, 32'hFFFF_FFFF, 6, 6, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule